// File: doc/BRIEF.md
# Serial Cyclic-Code Divider

This block divides a bit-serial polynomial over GF(2) by the fixed generator g(x) = 1 + x + x^3, which makes it both the checker and the encoder of a (7,4) cyclic code. A three-cell shift register with feedback takes one coefficient per accepted bit, highest power first. Each step emits one quotient bit. After the seventh bit the register holds the remainder.

In check mode a received 7-bit word is streamed in. The quotient comes out serially, and the remainder left in the register is the syndrome: zero means no error was detected. In encode mode the caller streams four data bits followed by three filler bits. The block ignores the values of the filler bits and divides by zeros in their place, which is the same as dividing the data times x^3. It then sends the full systematic codeword on a separate serial output: the four data bits as they arrive, followed by the three remainder bits. A synchronous clear starts each word.

Top module: `cyc_lfsr_divider`

## Requirements
- R1: With rst_n low, or in the cycle after clear is high, syndrome is 000 and quotient_out, q_valid, done, code_out and code_valid are all 0. Clear takes priority over bit_valid.
- R2: A bit is accepted on a rising edge with bit_valid high, clear low and fewer than seven bits taken since clear. With a cells s0..s2 and input d, the next state is s0 = s2^d, s1 = s0^s2, s2 = s1. The syndrome output shows the cells as syndrome[i] = s_i.
- R3: One cycle after each accepted bit, q_valid is high for one cycle and quotient_out equals s2 as it was before that bit. The last four quotient bits are the quotient, highest power first.
- R4: In check mode, the bit stream 1,0,0,0,1,0,1 (1 + x^2 + x^6) leaves syndrome 000 and gives the quotient bits 1,0,1,1 (1 + x + x^3).
- R5: In check mode, the same word with the x^3 coefficient flipped leaves s0=1, s1=1, s2=0, which is syndrome 3'b011.
- R6: done is high for exactly one cycle: the cycle after the seventh bit is accepted.
- R7: Once seven bits have been accepted, bit_valid has no effect until clear. A cycle with bit_valid low leaves the syndrome unchanged and keeps q_valid low.
- R8: In encode mode, bits 5 to 7 of a word are fed to the divider as 0 whatever bit_in is. After done, syndrome holds the remainder of data·x^3. Data x + x^3 gives syndrome 3'b011.
- R9: In encode mode, code_valid is high for one cycle after each of the first four accepted bits, with code_out equal to that data bit. It is then high for the three cycles that follow done, with code_out equal to s2, s1 and s0 in that order. In check mode code_valid stays low.
- R10: mode is sampled with the first accepted bit of a word. Changing mode later in the word has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Synchronous clear; starts a new word |
| bit_in | input | 1 | Serial coefficient, highest power first |
| bit_valid | input | 1 | bit_in is offered this cycle |
| mode | input | 1 | 0 = check word, 1 = encode data |
| quotient_out | output | 1 | Serial quotient bit |
| q_valid | output | 1 | quotient_out carries a new bit |
| syndrome | output | 3 | Register cells, bit i = s_i (remainder) |
| done | output | 1 | One-cycle pulse after the seventh bit |
| code_out | output | 1 | Serial codeword bit in encode mode |
| code_valid | output | 1 | code_out carries a new bit |

## Verification
The bench goes after the feedback taps with words whose register passes through every nonzero state. A tap on the wrong cell gives a nonzero syndrome for a valid word, or a zero syndrome for a corrupted one. Encode words carry ones in the filler positions: a design that divides by those bits instead of zeros produces the wrong check bits.

The bench also inserts idle gaps in the middle of a word and keeps offering bits after done. A counter that advances on idle cycles, or that fails to stop at seven, shifts the remainder. It switches mode in the middle of an encode word, which catches a design that reads mode live and drops into check behaviour. It checks the order of the check bits, which catches a design that sends s0 first and reverses the tail of the codeword.

// File: rtl/cld_pkg.sv
// Shared types and defaults for the serial cyclic-code divider.
// Assumes bit i of a generator constant is the coefficient of x^i.
package cld_pkg;

    typedef enum logic {
        OP_CHECK  = 1'b0,
        OP_ENCODE = 1'b1
    } op_mode_t;

    localparam int unsigned DEF_DEG   = 3;
    localparam int unsigned DEF_DATA  = 4;
    localparam logic [3:0]  DEF_GPOLY = 4'b1011;   // 1 + x + x^3

endpackage

// File: rtl/cld_lfsr.sv
// Division register: DEG cells with feedback from the top cell, taps taken
// from GPOLY. Assumes GPOLY[DEG] = 1 (top coefficient always connected).
// One step per asserted 'step'; quotient bit = top cell before the step.
module cld_lfsr #(
    parameter int unsigned DEG   = 3,
    parameter logic [DEG:0] GPOLY = 4'b1011
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           step,
    input  logic           din,
    output logic [DEG-1:0] rem,
    output logic           q_bit,
    output logic           q_valid
);

    logic [DEG-1:0] cell_q;
    logic [DEG-1:0] cell_d;
    logic           fb;

    assign fb  = cell_q[DEG-1];
    assign rem = cell_q;

    // Next-state network: one XOR tap per generator coefficient.
    generate
        for (genvar i = 0; i < DEG; i++) begin : g_cell
            if (i == 0) begin : g_head
                assign cell_d[0] = din ^ (GPOLY[0] & fb);
            end else begin : g_tap
                assign cell_d[i] = cell_q[i-1] ^ (GPOLY[i] & fb);
            end
        end
    endgenerate

    // Register update and quotient capture.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cell_q  <= '0;
            q_bit   <= 1'b0;
            q_valid <= 1'b0;
        end else begin
            q_valid <= step;
            if (step) begin
                cell_q <= cell_d;
                q_bit  <= fb;
            end
        end
    end

endmodule

// File: rtl/cld_seq.sv
// Word sequencer: counts accepted bits, latches the mode with the first bit,
// forces zero feed for the check-bit positions in encode mode, and pulses
// done after the last bit. Assumes clear precedes every word.
module cld_seq
    import cld_pkg::*;
#(
    parameter int unsigned CW_BITS   = 7,
    parameter int unsigned DATA_BITS = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clear,
    input  logic     bit_valid,
    input  op_mode_t mode_in,
    output logic     accept,
    output logic     zero_feed,
    output logic     data_phase,
    output logic     flush_en,
    output logic     done
);

    localparam int unsigned CNTW = $clog2(CW_BITS + 1);
    localparam logic [CNTW-1:0] LAST = CNTW'(CW_BITS - 1);
    localparam logic [CNTW-1:0] FULL = CNTW'(CW_BITS);
    localparam logic [CNTW-1:0] DLIM = CNTW'(DATA_BITS);

    logic [CNTW-1:0] cnt;
    op_mode_t        mode_q;
    op_mode_t        mode_eff;
    logic            full;

    // Decode of the word position and the effective mode.
    always_comb begin
        full       = (cnt == FULL);
        accept     = bit_valid && !full;
        mode_eff   = (cnt == '0) ? mode_in : mode_q;
        zero_feed  = (mode_eff == OP_ENCODE) && (cnt >= DLIM);
        data_phase = (mode_eff == OP_ENCODE) && (cnt < DLIM);
        flush_en   = full && (mode_q == OP_ENCODE);
    end

    // Bit counter, mode latch and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt    <= '0;
            mode_q <= OP_CHECK;
            done   <= 1'b0;
        end else begin
            done <= accept && (cnt == LAST);
            if (accept) begin
                cnt <= cnt + CNTW'(1);
                if (cnt == '0) begin
                    mode_q <= mode_in;
                end
            end
        end
    end

endmodule

// File: rtl/cld_emit.sv
// Codeword serializer for encode mode: echoes each data bit, then sends the
// remainder top cell first once flush_en is seen. Assumes rem is stable
// while flush_en is high.
module cld_emit #(
    parameter int unsigned DEG = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           data_load,
    input  logic           data_bit,
    input  logic           flush_en,
    input  logic [DEG-1:0] rem,
    output logic           code_out,
    output logic           code_valid
);

    localparam int unsigned FW = $clog2(DEG + 1);
    localparam logic [FW-1:0] FLIM = FW'(DEG);

    logic [FW-1:0]  fidx;
    logic [DEG-1:0] sh;
    logic [DEG-1:0] pick;

    // Source of the next check bit: the live remainder first, then the copy.
    assign pick = (fidx == '0) ? rem : sh;

    // Serial output register and check-bit shifter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            code_out   <= 1'b0;
            code_valid <= 1'b0;
            fidx       <= '0;
            sh         <= '0;
        end else begin
            code_valid <= 1'b0;
            if (data_load) begin
                code_out   <= data_bit;
                code_valid <= 1'b1;
            end else if (flush_en && (fidx < FLIM)) begin
                code_out   <= pick[DEG-1];
                code_valid <= 1'b1;
                sh         <= pick << 1;
                fidx       <= fidx + FW'(1);
            end
        end
    end

endmodule

// File: rtl/cyc_lfsr_divider.sv
// Top: bit-serial divider by a fixed generator, used as a cyclic-code
// checker (syndrome) or systematic encoder (check bits appended serially).
// Assumes mode is valid with the first bit and clear starts each word.
module cyc_lfsr_divider
    import cld_pkg::*;
#(
    parameter int unsigned  DEG       = DEF_DEG,
    parameter int unsigned  DATA_BITS = DEF_DATA,
    parameter logic [DEG:0] GPOLY     = DEF_GPOLY
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           bit_in,
    input  logic           bit_valid,
    input  logic           mode,
    output logic           quotient_out,
    output logic           q_valid,
    output logic [DEG-1:0] syndrome,
    output logic           done,
    output logic           code_out,
    output logic           code_valid
);

    localparam int unsigned CW_BITS = DATA_BITS + DEG;

    logic     accept;
    logic     zero_feed;
    logic     data_phase;
    logic     flush_en;
    logic     din;
    op_mode_t mode_t;

    assign mode_t = op_mode_t'(mode);
    assign din    = zero_feed ? 1'b0 : bit_in;

    cld_seq #(
        .CW_BITS   (CW_BITS),
        .DATA_BITS (DATA_BITS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .bit_valid  (bit_valid),
        .mode_in    (mode_t),
        .accept     (accept),
        .zero_feed  (zero_feed),
        .data_phase (data_phase),
        .flush_en   (flush_en),
        .done       (done)
    );

    cld_lfsr #(
        .DEG   (DEG),
        .GPOLY (GPOLY)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .step    (accept),
        .din     (din),
        .rem     (syndrome),
        .q_bit   (quotient_out),
        .q_valid (q_valid)
    );

    cld_emit #(
        .DEG (DEG)
    ) u_emit (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .data_load  (accept && data_phase),
        .data_bit   (bit_in),
        .flush_en   (flush_en),
        .rem        (syndrome),
        .code_out   (code_out),
        .code_valid (code_valid)
    );

endmodule

// File: rtl/cld_chk.sv
// Port-level protocol checker for cyc_lfsr_divider, attached by bind.
// Assumes the top's port names; counts code bits per word itself.
module cld_chk #(
    parameter int unsigned DEG     = 3,
    parameter int unsigned CW_BITS = 7
) (
    input logic           clk,
    input logic           rst_n,
    input logic           clear,
    input logic           bit_valid,
    input logic           q_valid,
    input logic           done,
    input logic           code_valid,
    input logic [DEG-1:0] syndrome
);

    localparam int unsigned CVW = $clog2(CW_BITS + 2);
    localparam logic [CVW-1:0] CV_MAX = CVW'(CW_BITS);

    logic [CVW-1:0] cv_cnt;

    // Counts code bits since the last clear, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cv_cnt <= '0;
        end else if (code_valid && (cv_cnt != '1)) begin
            cv_cnt <= cv_cnt + CVW'(1);
        end
    end

    // R1
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (syndrome == '0 && !done && !q_valid && !code_valid));

    // R3
    qvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |-> $past(bit_valid));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_valid && !clear) |=> $stable(syndrome));

    // R9
    code_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cv_cnt <= CV_MAX);

endmodule

bind cyc_lfsr_divider cld_chk #(
    .DEG     (DEG),
    .CW_BITS (DATA_BITS + DEG)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .bit_valid  (bit_valid),
    .q_valid    (q_valid),
    .done       (done),
    .code_valid (code_valid),
    .syndrome   (syndrome)
);

// File: tb/cyc_lfsr_divider_tb_top.sv
module cyc_lfsr_divider_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_valid = 1'b0;
    logic       mode = 1'b0;
    logic       quotient_out;
    logic       q_valid;
    logic [2:0] syndrome;
    logic       done;
    logic       code_out;
    logic       code_valid;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    cyc_lfsr_divider dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (clear),
        .bit_in       (bit_in),
        .bit_valid    (bit_valid),
        .mode         (mode),
        .quotient_out (quotient_out),
        .q_valid      (q_valid),
        .syndrome     (syndrome),
        .done         (done),
        .code_out     (code_out),
        .code_valid   (code_valid)
    );

    // {mode, bits(first fed = bit 6), syndrome, quotient stream, code stream}
    localparam logic [24:0] VEC [7] = '{
        {1'b0, 7'b1000101, 3'b000, 7'b0001011, 7'b0000000},
        {1'b0, 7'b1001101, 3'b011, 7'b0001010, 7'b0000000},
        {1'b1, 7'b1010111, 3'b011, 7'b0001001, 7'b1010011},
        {1'b1, 7'b1111101, 3'b111, 7'b0001101, 7'b1111111},
        {1'b1, 7'b0001010, 3'b011, 7'b0000001, 7'b0001011},
        {1'b0, 7'b0000000, 3'b000, 7'b0000000, 7'b0000000},
        {1'b0, 7'b1010010, 3'b001, 7'b0001001, 7'b0000000}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_word(input logic m, input logic [6:0] bits, input logic [2:0] esyn,
                            input logic [6:0] eq, input logic [6:0] ecode,
                            input int gap, input string syn_req);
        @(negedge clk);
        clear = 1'b1; bit_valid = 1'b0; mode = m;
        @(negedge clk);
        clear = 1'b0;
        chk(syndrome == 3'b000 && !q_valid && !done, "R1", syndrome, 0);
        for (int i = 0; i < 7; i++) begin
            bit_in = bits[6-i]; bit_valid = 1'b1;
            @(negedge clk);
            chk(q_valid && quotient_out == eq[6-i], "R3", {q_valid, quotient_out}, {1'b1, eq[6-i]});
            chk(done == (i == 6), "R6", done, (i == 6));
            if (m && i < 4)
                chk(code_valid && code_out == bits[6-i], "R9", {code_valid, code_out}, {1'b1, bits[6-i]});
            else if (!m)
                chk(!code_valid, "R9", code_valid, 0);
            if (gap > 0 && i < 6) begin
                bit_valid = 1'b0;
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    chk(!q_valid, "R7", q_valid, 0);
                end
            end
        end
        bit_valid = 1'b0;
        chk(syndrome == esyn, syn_req, syndrome, esyn);
        if (m) begin
            for (int j = 0; j < 3; j++) begin
                @(negedge clk);
                chk(code_valid && code_out == ecode[2-j], "R9", {code_valid, code_out}, {1'b1, ecode[2-j]});
                chk(!done, "R6", done, 0);
            end
            @(negedge clk);
            chk(!code_valid, "R9", code_valid, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        string vreq [7] = '{"R4", "R5", "R8", "R8", "R8", "R2", "R2"};
        logic [2:0] held;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(syndrome == 3'b000 && !quotient_out && !q_valid && !done && !code_out && !code_valid,
            "R1", {syndrome, quotient_out, q_valid, done, code_out, code_valid}, 0);
        rst_n = 1'b1;

        // Vector table walk: R2 R3 R4 R5 R6 R8 R9
        for (int v = 0; v < 7; v++) begin
            run_word(VEC[v][24], VEC[v][23:17], VEC[v][16:14], VEC[v][13:7], VEC[v][6:0], 0, vreq[v]);
        end

        // R7: idle gaps inside a word give the same result as without gaps
        run_word(VEC[0][24], VEC[0][23:17], VEC[0][16:14], VEC[0][13:7], VEC[0][6:0], 2, "R7");

        // R7: bits offered after the seventh are ignored until clear
        run_word(VEC[1][24], VEC[1][23:17], VEC[1][16:14], VEC[1][13:7], VEC[1][6:0], 0, "R5");
        held = syndrome;
        for (int k = 0; k < 3; k++) begin
            bit_in = 1'b1; bit_valid = 1'b1;
            @(negedge clk);
            chk(!q_valid && !done && syndrome == held, "R7", {q_valid, done, syndrome}, {2'b00, held});
        end
        bit_valid = 1'b0;

        // R10: mode changed after the first bit keeps encode behaviour
        @(negedge clk);
        clear = 1'b1; mode = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        for (int i = 0; i < 7; i++) begin
            bit_in = VEC[2][23-i]; bit_valid = 1'b1;
            @(negedge clk);
            mode = 1'b0;
        end
        bit_valid = 1'b0;
        chk(syndrome == 3'b011, "R10", syndrome, 3'b011);
        @(negedge clk);
        chk(code_valid && code_out == 1'b0, "R10", {code_valid, code_out}, 2'b10);

        // R1: reset in the middle of a word clears everything
        @(negedge clk);
        clear = 1'b1; mode = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        for (int i = 0; i < 3; i++) begin
            bit_in = 1'b1; bit_valid = 1'b1;
            @(negedge clk);
        end
        rst_n = 1'b0;
        @(negedge clk);
        chk(syndrome == 3'b000 && !q_valid && !code_valid && !done, "R1",
            {syndrome, q_valid, code_valid, done}, 0);
        bit_valid = 1'b0;
        rst_n = 1'b1;

        // R1: clear wins over bit_valid in the same cycle
        @(negedge clk);
        clear = 1'b1; bit_valid = 1'b1; bit_in = 1'b1;
        @(negedge clk);
        chk(syndrome == 3'b000 && !q_valid, "R1", {syndrome, q_valid}, 0);
        clear = 1'b0; bit_valid = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule